// File: doc/BRIEF.md
# Reset Pin Glitch Filter

This block cleans up an active-low external reset pin before it reaches the chip's reset generator. The raw pin is asynchronous to the fabric clock, so it first passes through a short chain of flip-flops. A saturating up/down integrator then measures how long the pin has been held low. Brief noise spikes and contact bounce are absorbed. A level held low for long enough turns into a steady, registered reset request.

The integrator counts up on every clock in which the synchronized pin is low. It counts down in every clock in which the pin is high. Its range runs from zero to a threshold equal to the clock rate in cycles per microsecond times a time constant in microseconds. The defaults are 250 cycles/µs and 12 µs, which gives a threshold of 3000. The request sets when the count reaches the threshold and clears only when the count has drained back to zero. This gap gives the output hysteresis.

With the defaults, any low pulse of 1 µs or shorter is always rejected, and any low pulse of 26 µs or longer is always accepted. The analog input stage and the downstream reset sequencing lie outside this block.

Top module: `rpf_reset_filter`

## Requirements
- R1: While `rst` is high and after it falls with the pin held high, `reset_req` is 0.
- R2: A single low pulse of at most CYC_PER_US clock cycles (1 µs), starting from an idle filter, never raises `reset_req`.
- R3: The integrator count rises by one per cycle while the synchronized pin is low and falls by one while it is high. It never leaves the range 0 to THRESH = CYC_PER_US*TC_US (3000 by default).
- R4: From an idle filter with the pin held low, `reset_req` first reads 1 exactly THRESH+3 clock edges after the pin falls: two synchronizer stages, THRESH count steps and one output register.
- R5: From a saturated count with the pin returned high and held high, `reset_req` first reads 0 exactly THRESH+3 clock edges after the pin rises.
- R6: Any low pulse lasting 26 µs (26*CYC_PER_US cycles) or longer raises `reset_req` before the pulse ends.
- R7: Once `reset_req` is 1, a high glitch shorter than THRESH cycles does not clear it.
- R8: A bouncing pin whose low time exceeds its high time accumulates and eventually raises `reset_req`. A pulse train whose high time exceeds its low time never raises it.
- R9: Any single low pulse shorter than THRESH cycles, starting from an idle filter, never raises `reset_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_n_raw | input | 1 | Raw asynchronous reset pin, low requests reset |
| reset_req | output | 1 | Filtered, registered pin-reset request (active high) |

## Verification
The in-RTL assertions check four things on every cycle. The count stays within 0 to THRESH, and it moves by at most one step per clock. The request rises only after the count has reached THRESH, and it falls only after the count has reached zero. Three properties depend on the history of the pin, and only the bench scenarios can show them. These are the exact assert and release latencies, the rejection of short and random sub-threshold pulses, and the outcome of bounce trains. The bench judges these against window sums computed from the requirements.

// File: rtl/rpf_pkg.sv
package rpf_pkg;
  function automatic int thresh_cycles(input int cyc_per_us, input int tc_us);
    return cyc_per_us * tc_us;
  endfunction

  function automatic int cnt_width(input int thresh);
    return $clog2(thresh + 1);
  endfunction
endpackage

// File: rtl/rpf_sync.sv
module rpf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= {sr[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/rpf_integrator.sv
module rpf_integrator #(
  parameter int THRESH = 3000,
  parameter int CW     = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          low,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = CW'(THRESH);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (low && cnt != TOP)
      cnt <= cnt + 1'b1;
    else if (!low && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP); // R3

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt + 1'b1 == $past(cnt))); // R3
endmodule

// File: rtl/rpf_hyst.sv
module rpf_hyst #(
  parameter int THRESH = 3000,
  parameter int CW     = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  output logic          req
);
  localparam logic [CW-1:0] TOP = CW'(THRESH);

  always_ff @(posedge clk) begin
    if (rst)               req <= 1'b0;
    else if (cnt == TOP)   req <= 1'b1;
    else if (cnt == '0)    req <= 1'b0;
  end
endmodule

// File: rtl/rpf_reset_filter.sv
module rpf_reset_filter #(
  parameter int CYC_PER_US  = 250,
  parameter int TC_US       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n_raw,
  output logic reset_req
);
  import rpf_pkg::*;

  localparam int THRESH = thresh_cycles(CYC_PER_US, TC_US);
  localparam int CW     = cnt_width(THRESH);
  localparam logic [CW-1:0] TOP = CW'(THRESH);

  logic          pin_n_s;
  logic [CW-1:0] cnt;

  rpf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pin_n_raw),
    .dout(pin_n_s)
  );

  rpf_integrator #(.THRESH(THRESH), .CW(CW)) u_integ (
    .clk(clk),
    .rst(rst),
    .low(~pin_n_s),
    .cnt(cnt)
  );

  rpf_hyst #(.THRESH(THRESH), .CW(CW)) u_hyst (
    .clk(clk),
    .rst(rst),
    .cnt(cnt),
    .req(reset_req)
  );

  AST_REQ_SET_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_req) |-> $past(cnt) == TOP); // R4

  AST_REQ_CLR_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(reset_req) |-> $past(cnt) == '0); // R5
endmodule

// File: tb/tb_rpf_reset_filter.sv
module tb_rpf_reset_filter;
  localparam int CYC    = 250;
  localparam int TC     = 12;
  localparam int TH     = CYC * TC;
  localparam int LAT    = TH + 3;
  localparam int LONG   = 26 * CYC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin = 1'b1;
  logic reset_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rpf_reset_filter #(.CYC_PER_US(CYC), .TC_US(TC), .SYNC_STAGES(2)) dut (
    .clk      (clk),
    .rst      (rst),
    .pin_n_raw(pin),
    .reset_req(reset_req)
  );

  function automatic bit accepts_long(input int len);
    return len >= LAT;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic watch(input int n, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (reset_req) seen = 1'b1;
    end
  endtask

  initial begin
    bit seen;
    int len;
    int unused_seed;
    unused_seed = $urandom(32'd20240607);

    cyc(5);
    chk("R1 during reset", reset_req, 1'b0);
    rst = 1'b0;
    watch(50, seen);
    chk("R1 idle after reset", seen, 1'b0);

    // R2: 1 us pulse rejected
    pin = 1'b0; watch(CYC, seen); pin = 1'b1;
    begin bit s2; watch(CYC + 10, s2); seen |= s2; end
    chk("R2 1us pulse", seen, 1'b0);

    // R4: exact assert latency
    pin = 1'b0;
    cyc(LAT - 1);
    chk("R4 before latency", reset_req, 1'b0);
    cyc(1);
    chk("R4 at latency", reset_req, 1'b1);
    cyc(20);

    // R7: high glitch shorter than TH keeps request
    pin = 1'b1; watch(TH - 100, seen); pin = 1'b0;
    begin
      bit dropped = 1'b0;
      for (int i = 0; i < TH; i++) begin
        @(negedge clk);
        if (!reset_req) dropped = 1'b1;
      end
      chk("R7 hysteresis hold", dropped, 1'b0);
    end
    cyc(TH + 10);

    // R5: exact release latency from saturated count
    pin = 1'b1;
    cyc(LAT - 1);
    chk("R5 before latency", reset_req, 1'b1);
    cyc(1);
    chk("R5 at latency", reset_req, 1'b0);
    cyc(20);

    // R9: random sub-threshold pulses rejected
    for (int k = 0; k < 12; k++) begin
      len = 1 + int'($urandom % (TH - 1));
      pin = 1'b0; watch(len, seen); pin = 1'b1;
      begin bit s2; watch(len + 10, s2); seen |= s2; end
      chk($sformatf("R9 short pulse len=%0d", len), seen, 1'b0);
    end

    // R9 boundary: TH-1 cycles
    pin = 1'b0; watch(TH - 1, seen); pin = 1'b1;
    begin bit s2; watch(TH + 10, s2); seen |= s2; end
    chk("R9 pulse TH-1", seen, 1'b0);

    // R6: long pulses accepted, including exactly 26 us
    for (int k = 0; k < 3; k++) begin
      len = (k == 0) ? LONG : LAT + int'($urandom % (LONG - LAT + 1));
      pin = 1'b0; cyc(len);
      chk($sformatf("R6 long pulse len=%0d", len), reset_req, logic'(accepts_long(len)));
      pin = 1'b1; cyc(TH + 10);
      chk("R6 drained", reset_req, 1'b0);
    end

    // R8: bounce with more low than high accumulates
    for (int k = 0; k < TH / 20 + 5; k++) begin
      pin = 1'b0; cyc(40);
      pin = 1'b1; cyc(20);
    end
    chk("R8 bounce low-dominant", reset_req, 1'b1);
    pin = 1'b1; cyc(TH + 10);

    // R8: high-dominant train never asserts
    seen = 1'b0;
    for (int k = 0; k < 150; k++) begin
      bit s2;
      pin = 1'b0; watch(20, s2); seen |= s2;
      pin = 1'b1; watch(40, s2); seen |= s2;
    end
    chk("R8 bounce high-dominant", seen, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog timeout actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule